// File: doc/BRIEF.md
# Sixteen-Source Prioritized IRQ/FIQ Interrupt Controller

This block is a second-level interrupt controller for up to sixteen request lines. Each line, ORed with a bit from a software trigger register, is captured into a pending register. Capture is either edge-sensitive or level-sensitive, chosen per source. Pending sources that are not masked compete for one of two processor outputs. The low-priority `irq_out` and the fast `fiq_out` each have their own arbiter, and both evaluate in the same cycle. A per-source configuration word selects the capture mode, a 4-bit priority and the output route.

Software uses a plain register bus with one write strobe and one read strobe. Two read-only number registers report the winning source for each output. Reading a number register acknowledges the winning source by clearing its pending bit. A single disable bit turns the whole handler off and reflects that state on `handler_off`. The bus has no back-pressure. A write takes effect at the clock edge where `bus_wr` is sampled high. Read data is registered and appears on `bus_rdata` in the cycle after `bus_rd` is sampled high.

Register word addresses:
- 0x00: pending
- 0x04: mask
- 0x08: IRQ number
- 0x0C: FIQ number
- 0x10: software trigger
- 0x14: disable
- 0x40 + 4·i: configuration of source i

Top module: `irqc_top`

## Requirements
- R1: A source configured edge-sensitive (config bit 0 = 1) sets its pending bit once on each 0→1 transition of its merged request, and it does not re-set while the request stays high. A level-sensitive source (bit 0 = 0) sets its pending bit on every cycle the merged request is high, so that set wins over a clear in the same cycle.
- R2: A write to the pending register (0x00) clears every bit written as 0 and leaves every bit written as 1 unchanged. A read of 0x00 returns the pending bits in bits 15:0.
- R3: Writing 1 to bit i of the software trigger register (0x10), after it held 0, raises source i's merged request. An edge-sensitive source i becomes pending in the following cycle. Hardware never clears the trigger register, and reading 0x10 always returns 0.
- R4: The mask register (0x04, bit i = 1 masks source i) resets to all ones. A masked source stays pending but drives neither output. Clearing its mask bit lets it drive its output.
- R5: Among eligible sources on the same route, the lowest priority value (config bits 4:1) wins, and a tie goes to the lower source number. Reading the number register returns the winner's index in bits 7:0.
- R6: Config bit 5 routes a source to `fiq_out` (1) or to `irq_out` (0). The two outputs are arbitrated independently and can be high together.
- R7: Reading 0x08 (IRQ) or 0x0C (FIQ) clears the pending bit of the source it reports. When no eligible source is on that route, the read returns 0xFF and clears nothing.
- R8: Bit 0 of the disable register (0x14) drives `handler_off`. While it is 1, both outputs stay low, both number reads return 0xFF, and no read acknowledges a source. Pending bits are still captured.
- R9: After reset, pending, trigger, disable and all config words are 0, the mask is 0xFFFF, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req | input | NSRC | External request lines |
| bus_addr | input | 8 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (reading a number register acknowledges) |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Low-priority interrupt to the processor |
| fiq_out | output | 1 | Fast interrupt to the processor |
| handler_off | output | 1 | High while the handler is globally disabled |

## Verification
The random part programs random priorities and routes, then fires random request patterns. It drains each route through its number register and compares the order against a bench-computed winner. An arbiter that broke ties toward the higher index, or that mixed up the routes, would report sources out of order. Directed cases cover several errors:
- A level source being cleared while its input stays high: a design without set-over-clear priority would lose the request.
- An edge source held high after a clear: a design that re-latches it would raise a spurious interrupt.
- A read with nothing pending: the design must return 0xFF, and must not clear bit 0 by accident.
- Reads while the handler is disabled: these must neither report a source nor acknowledge one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 8;
  localparam int PRIO_W = 4;

  localparam logic [ADDR_W-1:0] A_PEND   = 8'h00;
  localparam logic [ADDR_W-1:0] A_MASK   = 8'h04;
  localparam logic [ADDR_W-1:0] A_IRQN   = 8'h08;
  localparam logic [ADDR_W-1:0] A_FIQN   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_SWTRIG = 8'h10;
  localparam logic [ADDR_W-1:0] A_GDIS   = 8'h14;
  localparam logic [ADDR_W-1:0] A_CFG    = 8'h40;

  localparam logic [31:0] NO_SRC = 32'h0000_00FF;

  // per-source configuration word: bit0 edge mode, bits 4:1 priority, bit5 fast route
  typedef struct packed {
    logic              to_fiq;
    logic [PRIO_W-1:0] prio;
    logic              edge_mode;
  } src_cfg_t;

  localparam int CFG_W = $bits(src_cfg_t);
endpackage

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] edge_mode,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] set_v;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      set_v[i] = edge_mode[i] ? (req[i] & ~prev_q[i]) : req[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend   <= '0;
    end else begin
      prev_q <= req;
      // a new request in the same cycle outranks any clear
      pend   <= (pend & ~clr) | set_v;
    end
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 4,
  localparam int ID_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]        elig,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic                   hit,
  output logic [ID_W-1:0]        win
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    hit    = 1'b0;
    win    = '0;
    best_p = '1;
    for (int i = 0; i < NSRC; i++) begin
      // strict compare keeps the lower index on equal priority
      if (elig[i] && (!hit || prio_flat[i*PRIO_W +: PRIO_W] < best_p)) begin
        hit    = 1'b1;
        win    = ID_W'(i);
        best_p = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   ext_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              irq_out,
  output logic              fiq_out,
  output logic              handler_off
);
  localparam int ID_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int NROUTE = 2;

  src_cfg_t        cfg_q [NSRC];
  logic [NSRC-1:0] mask_q, swtrig_q, pend_q;
  logic            gdis_q;

  logic [NSRC-1:0]        edge_vec, fiq_vec, clr_vec, ack_vec, elig_base;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NROUTE-1:0][NSRC-1:0] elig_rt;
  logic [NROUTE-1:0]           hit_rt, rd_num;
  logic [NROUTE-1:0][ID_W-1:0] win_rt;

  logic [ADDR_W-1:0] cfg_off;
  logic              cfg_sel;
  logic [31:0]       rd_val;

  assign cfg_off = bus_addr - A_CFG;
  assign cfg_sel = (bus_addr >= A_CFG) && (cfg_off[1:0] == 2'b00) &&
                   (cfg_off[ADDR_W-1:2] < (ADDR_W-2)'(NSRC));

  for (genvar i = 0; i < NSRC; i++) begin : g_unpack
    assign edge_vec[i] = cfg_q[i].edge_mode;
    assign fiq_vec[i]  = cfg_q[i].to_fiq;
    assign prio_flat[i*PRIO_W +: PRIO_W] = cfg_q[i].prio;
  end

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      swtrig_q <= '0;
      gdis_q   <= 1'b0;
      for (int i = 0; i < NSRC; i++) cfg_q[i] <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MASK)   mask_q   <= bus_wdata[NSRC-1:0];
      if (bus_addr == A_SWTRIG) swtrig_q <= bus_wdata[NSRC-1:0];
      if (bus_addr == A_GDIS)   gdis_q   <= bus_wdata[0];
      for (int i = 0; i < NSRC; i++) begin
        if (cfg_sel && cfg_off[ADDR_W-1:2] == (ADDR_W-2)'(i))
          cfg_q[i] <= src_cfg_t'(bus_wdata[CFG_W-1:0]);
      end
    end
  end

  // capture of merged requests
  assign clr_vec = ((bus_wr && bus_addr == A_PEND) ? ~bus_wdata[NSRC-1:0] : '0) | ack_vec;

  irqc_pend #(.NSRC(NSRC)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (ext_req | swtrig_q),
    .edge_mode (edge_vec),
    .clr       (clr_vec),
    .pend      (pend_q)
  );

  // eligibility and one arbiter per route (0 = IRQ, 1 = FIQ)
  assign elig_base  = pend_q & ~mask_q & {NSRC{~gdis_q}};
  assign elig_rt[0] = elig_base & ~fiq_vec;
  assign elig_rt[1] = elig_base & fiq_vec;
  assign rd_num[0]  = bus_rd && (bus_addr == A_IRQN);
  assign rd_num[1]  = bus_rd && (bus_addr == A_FIQN);

  for (genvar r = 0; r < NROUTE; r++) begin : g_route
    irqc_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
      .elig      (elig_rt[r]),
      .prio_flat (prio_flat),
      .hit       (hit_rt[r]),
      .win       (win_rt[r])
    );
  end

  always_comb begin
    ack_vec = '0;
    for (int r = 0; r < NROUTE; r++) begin
      if (rd_num[r] && hit_rt[r]) ack_vec[win_rt[r]] = 1'b1;
    end
  end

  // read path
  always_comb begin
    rd_val = '0;
    unique case (bus_addr)
      A_PEND:  rd_val[NSRC-1:0] = pend_q;
      A_MASK:  rd_val[NSRC-1:0] = mask_q;
      A_IRQN:  rd_val = hit_rt[0] ? 32'(win_rt[0]) : NO_SRC;
      A_FIQN:  rd_val = hit_rt[1] ? 32'(win_rt[1]) : NO_SRC;
      A_GDIS:  rd_val[0] = gdis_q;
      default: begin
        for (int i = 0; i < NSRC; i++) begin
          if (cfg_sel && cfg_off[ADDR_W-1:2] == (ADDR_W-2)'(i))
            rd_val[CFG_W-1:0] = cfg_q[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

  assign irq_out     = hit_rt[0];
  assign fiq_out     = hit_rt[1];
  assign handler_off = gdis_q;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int NSRC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              irq_out,
  input logic              fiq_out,
  input logic              handler_off,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   mask_q
);
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    handler_off |-> (!irq_out && !fiq_out));

  p_off_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_GDIS) |=> (handler_off == $past(bus_wdata[0])));

  p_trig_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_SWTRIG) |=> (bus_rdata == 32'd0));

  p_ones_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PEND) |=>
      ((pend_q & $past(pend_q & bus_wdata[NSRC-1:0])) == $past(pend_q & bus_wdata[NSRC-1:0])));

  p_irq_empty_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_IRQN && !irq_out) |=> (bus_rdata == NO_SRC));

  p_fiq_empty_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_FIQN && !fiq_out) |=> (bus_rdata == NO_SRC));

  p_irq_valid_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_IRQN && irq_out) |=> (bus_rdata < 32'(NSRC)));

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~mask_q) == '0) |-> (!irq_out && !fiq_out));
endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .irq_out     (irq_out),
  .fiq_out     (fiq_out),
  .handler_off (handler_off),
  .pend_q      (pend_q),
  .mask_q      (mask_q)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
  localparam int NSRC = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] ext_req = '0;
  logic [7:0]      bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic            bus_rd = 1'b0;
  logic [31:0]     bus_rdata;
  logic            irq_out, fiq_out, handler_off;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int unsigned b_prio  [NSRC];
  bit          b_route [NSRC];

  always #2 clk = ~clk;

  irqc_top #(.NSRC(NSRC)) i_irqc_top (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .fiq_out(fiq_out), .handler_off(handler_off)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] pat);
    @(negedge clk);
    ext_req = pat;
    @(negedge clk);
    ext_req = '0;
  endtask

  task automatic set_cfg(input int i, input bit edg, input int unsigned pr, input bit fq);
    b_prio[i] = pr; b_route[i] = fq;
    wr(8'(8'h40 + 4 * i), {26'd0, fq, 4'(pr), edg});
  endtask

  function automatic int winner(input logic [NSRC-1:0] bits, input bit route);
    int best = -1;
    for (int i = 0; i < NSRC; i++) begin
      if (bits[i] && b_route[i] == route && (best < 0 || b_prio[i] < b_prio[best])) best = i;
    end
    return best;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < NSRC; i++) begin b_prio[i] = 0; b_route[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    check(!irq_out && !fiq_out && !handler_off, "R9 outputs after reset", {irq_out, fiq_out, handler_off}, 0);
    rd(8'h00, d); check(d == 0, "R9 pending reset", d, 0);
    rd(8'h04, d); check(d == 32'hFFFF, "R9 mask reset", d, 32'hFFFF);
    rd(8'h08, d); check(d == 32'hFF, "R7 empty IRQ number", d, 32'hFF);

    // R4 masked source stays pending but silent
    set_cfg(3, 1, 5, 0);
    pulse(16'h0008);
    check(!irq_out, "R4 masked source silent", irq_out, 0);
    rd(8'h00, d); check(d == 32'h8, "R4 masked source still pending", d, 32'h8);
    wr(8'h04, 32'h0);
    check(irq_out, "R4 unmasked source drives IRQ", irq_out, 1);

    // R2 write-one holds, write-zero clears
    wr(8'h00, 32'hFFFF);
    rd(8'h00, d); check(d == 32'h8, "R2 write ones keeps pending", d, 32'h8);
    wr(8'h00, 32'hFFF7);
    rd(8'h00, d); check(d == 32'h0, "R2 write zero clears", d, 0);

    // R1 edge source held high is not re-latched after clear
    @(negedge clk); ext_req = 16'h0008;
    @(negedge clk); @(negedge clk);
    wr(8'h00, 32'h0);
    rd(8'h00, d); check(d == 32'h0, "R1 edge held high no re-latch", d, 0);
    // R1 level source held high survives a clear
    set_cfg(5, 0, 2, 0);
    @(negedge clk); ext_req = 16'h0020;
    @(negedge clk);
    wr(8'h00, 32'h0);
    rd(8'h00, d); check(d == 32'h20, "R1 level source re-sets", d, 32'h20);
    @(negedge clk); ext_req = '0;
    wr(8'h00, 32'h0);
    rd(8'h00, d); check(d == 32'h0, "R1 level source released", d, 0);

    // R3 software trigger
    set_cfg(7, 1, 1, 0);
    wr(8'h10, 32'h80);
    rd(8'h00, d); check(d == 32'h80, "R3 software edge sets pending", d, 32'h80);
    rd(8'h10, d); check(d == 0, "R3 trigger reads zero", d, 0);
    wr(8'h00, 32'h0);
    rd(8'h00, d); check(d == 0, "R3 trigger kept high gives no new edge", d, 0);
    wr(8'h10, 32'h0);
    wr(8'h10, 32'h80);
    rd(8'h00, d); check(d == 32'h80, "R3 second software edge", d, 32'h80);
    wr(8'h10, 32'h0);
    wr(8'h00, 32'h0);

    // R5 tie goes to lower index; R7 acknowledge
    set_cfg(2, 1, 3, 0);
    set_cfg(9, 1, 3, 0);
    pulse(16'h0204);
    rd(8'h08, d); check(d == 2, "R5 tie lower index first", d, 2);
    rd(8'h08, d); check(d == 9, "R7 ack exposes next source", d, 9);
    rd(8'h08, d); check(d == 32'hFF, "R7 drained IRQ returns FF", d, 32'hFF);

    // R6 independent routes
    set_cfg(4, 1, 7, 1);
    pulse(16'h0014);
    check(irq_out && fiq_out, "R6 both outputs high", {irq_out, fiq_out}, 2'b11);
    rd(8'h0C, d); check(d == 4, "R6 FIQ number", d, 4);
    check(irq_out && !fiq_out, "R6 FIQ ack leaves IRQ", {irq_out, fiq_out}, 2'b10);

    // R8 global disable
    wr(8'h14, 32'h1);
    check(handler_off && !irq_out && !fiq_out, "R8 disabled outputs", {handler_off, irq_out, fiq_out}, 3'b100);
    rd(8'h08, d); check(d == 32'hFF, "R8 disabled number read", d, 32'hFF);
    rd(8'h00, d); check(d == 32'h4, "R8 read while off acks nothing", d, 32'h4);
    wr(8'h14, 32'h0);
    check(irq_out && !handler_off, "R8 re-enable restores IRQ", {irq_out, handler_off}, 2'b10);
    wr(8'h00, 32'h0);

    // R5 R6 R7 random priorities, routes and request patterns
    for (int i = 0; i < NSRC; i++) set_cfg(i, 1, $urandom % 16, 1'($urandom % 2));
    for (int it = 0; it < 25; it++) begin
      logic [NSRC-1:0] pat, rem;
      int w;
      pat = NSRC'($urandom);
      wr(8'h00, 32'h0);
      pulse(pat);
      check(irq_out == (winner(pat, 0) >= 0), "R6 random IRQ level", irq_out, (winner(pat, 0) >= 0));
      check(fiq_out == (winner(pat, 1) >= 0), "R6 random FIQ level", fiq_out, (winner(pat, 1) >= 0));
      for (int r = 0; r < 2; r++) begin
        rem = pat;
        for (int k = 0; k <= NSRC; k++) begin
          w = winner(rem, 1'(r));
          rd(r == 0 ? 8'h08 : 8'h0C, d);
          if (w < 0) begin
            check(d == 32'hFF, "R7 random drained route", d, 32'hFF);
            break;
          end
          check(d == 32'(w), "R5 random arbitration order", d, 32'(w));
          rem[w] = 1'b0;
        end
      end
      rd(8'h00, d); check(d == 0, "R7 random all acknowledged", d, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule